// File: doc/BRIEF.md
# Framed SPI Register Target with CRC-8 Protection

This block is the device side of a serial register port. A host talks to it over a four-wire SPI link in mode 0: clock idle low, data sampled on the rising clock edge and changed on the falling edge, bits most significant first. Each access is a frame that opens with a command byte and runs while chip select is held low. The command byte names a 7-bit register address and says whether the host reads or writes. A 16-bit register value follows, and an 8-bit CRC can protect the frame.

The register file is small. It holds a fixed identity word, a status word with a sticky CRC-error flag, a configuration word whose lowest bit turns on CRC checking of incoming writes, and a bank of general 16-bit storage words. Every address has its own read and write permissions. A read always returns a CRC byte after the data, so the host can check the response whether or not incoming checking is turned on. Raising chip select before a frame is complete cancels that frame. The SPI pins are synchronised to the system clock, which must run at least eight times faster than the SPI clock.

Top module: `spi_regtgt`

## Requirements
- R1: After reset, the status word, the configuration word (CRC checking off) and all storage words read as zero, and spi_miso is low.
- R2: The command byte is sent first, most significant bit first. Bits 7:1 hold the register address and bit 0 is 1 for a read and 0 for a write. 16-bit values travel high byte first. Address 0 reads the identity value 16'hA70C.
- R3: In a read frame the target sends the 16 data bits and then a CRC byte. The CRC is a reflected CRC-8 with polynomial 8'h8C, processed LSB first from initial value 8'h00, over the command byte, the data high byte and the data low byte.
- R4: While configuration bit 0 is 0, a write frame is the command byte plus two data bytes, and it takes effect once the 24th bit has been received.
- R5: While configuration bit 0 is 1, a write frame also carries a fourth CRC byte, computed as in R3 over the command and data bytes. It takes effect at the 32nd bit only if that CRC matches. A 24-bit frame is then incomplete and has no effect.
- R6: With checking on, a write whose CRC does not match is discarded and sets status bit 0 (address 1). Nothing clears that bit except reset.
- R7: Writable addresses are 3 through 13 (3 is the configuration word). A write to any other address, including 0, 1, 2, 14 and anything above 14, changes nothing.
- R8: Addresses 0, 1 and 3 through 14 can be read, and 14 reads as zero. A read of address 2 or of an address above 14 returns zero data, still followed by a valid CRC.
- R9: Raising spi_cs_n before a frame is complete aborts it with no effect on any register.
- R10: spi_miso is low whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SPI clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select that frames each access |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low while deselected |

## Verification
A wrong bit counter or command decode shows up on the next read as shifted data or a CRC byte that no longer matches the bench's own CRC of the command and data, so the bench catches it within one frame. A wrong permission decision or a wrong commit decision (an aborted, short or CRC-failed frame that was applied anyway) stays hidden until that register is read back. For that reason the bench reads the touched addresses right after each directed case and reads the whole map after the random phase. A sticky flag that clears by mistake, or a CRC check on the wrong bytes, appears in the status word on the very next read of address 1.

// File: rtl/regtgt_pkg.sv
package regtgt_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 16;
  localparam int CRC_W  = 8;
  localparam int ADDR_W = CMD_W - 1;
  localparam int SHORT_FRAME = CMD_W + DATA_W;
  localparam int LONG_FRAME  = CMD_W + DATA_W + CRC_W;
  localparam int RESP_W      = DATA_W + CRC_W;
  localparam int CNT_W       = $clog2(LONG_FRAME + 1) + 1;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h8C;

  // one byte through the reflected CRC-8, least significant bit first
  function automatic logic [CRC_W-1:0] crc8_upd(input logic [CRC_W-1:0] crc_in,
                                                 input logic [7:0] dat);
    logic [CRC_W-1:0] c;
    c = crc_in ^ dat;
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] crc8_frame(input logic [CMD_W-1:0] cmd,
                                                   input logic [DATA_W-1:0] dat);
    return crc8_upd(crc8_upd(crc8_upd(8'h00, cmd), dat[15:8]), dat[7:0]);
  endfunction
endpackage

// File: rtl/regtgt_sync.sv
module regtgt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/regtgt_regfile.sv
module regtgt_regfile
  import regtgt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 16'hA70C,
  parameter int WR_FIRST = 3,
  parameter int WR_LAST  = 13,
  parameter int RD_LAST  = 14,
  parameter int RD_HOLE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_set,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              crc_chk_en,
  output logic              err_flag
);
  localparam int NSTORE = WR_LAST - WR_FIRST + 1;

  logic [DATA_W-1:0] store_q [NSTORE];
  logic              err_q, err_d;
  logic              wr_ok;

  assign wr_ok = wr_req && (int'(wr_addr) >= WR_FIRST) && (int'(wr_addr) <= WR_LAST);

  genvar i;
  generate
    for (i = 0; i < NSTORE; i++) begin : g_word
      logic hit;
      assign hit = wr_ok && (int'(wr_addr) == WR_FIRST + i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q[i] <= '0;
        else if (hit) store_q[i] <= wr_data;
      end
    end
  endgenerate

  always_comb err_d = err_q | err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= err_d;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == 0) rd_data = ID_VALUE;
    else if (int'(rd_addr) == 1) rd_data = {{(DATA_W-1){1'b0}}, err_q};
    else if (int'(rd_addr) >= WR_FIRST && int'(rd_addr) <= WR_LAST)
      rd_data = store_q[int'(rd_addr) - WR_FIRST];
    else if (int'(rd_addr) == RD_HOLE || int'(rd_addr) > RD_LAST)
      rd_data = '0;
  end

  assign crc_chk_en = store_q[0][0];
  assign err_flag   = err_q;
endmodule

// File: rtl/regtgt_frame.sv
module regtgt_frame
  import regtgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              crc_chk_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_set,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              miso_bit
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_S   = CNT_W'(SHORT_FRAME - 1);
  localparam logic [CNT_W-1:0] LAST_L   = CNT_W'(LONG_FRAME - 1);
  localparam logic [CNT_W-1:0] CMD_DONE = CNT_W'(CMD_W);

  logic                  sclk_q;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [LONG_FRAME-1:0] sh_q, sh_d;
  logic [RESP_W-1:0]     tx_q, tx_d;
  logic                  rd_q, rd_d;
  logic                  eval_q, eval_d, long_q, long_d;
  logic [CMD_W-1:0]      f_cmd;
  logic [DATA_W-1:0]     f_dat;
  logic                  crc_ok;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!cs_act) begin
      cnt_d = '0;
    end else if (sclk_rise && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[LONG_FRAME-2:0], mosi_s};
    end
    eval_d = cs_act && sclk_rise &&
             ((crc_chk_en && cnt_q == LAST_L) || (!crc_chk_en && cnt_q == LAST_S));
    long_d = crc_chk_en;
  end

  // response shifter: loaded on the falling edge after the command byte
  always_comb begin
    tx_d = tx_q;
    rd_d = rd_q;
    if (!cs_act) begin
      rd_d = 1'b0;
    end else if (sclk_fall && cnt_q == CMD_DONE && sh_q[0]) begin
      tx_d = {rd_data, crc8_frame(sh_q[CMD_W-1:0], rd_data)};
      rd_d = 1'b1;
    end else if (sclk_fall && cnt_q > CMD_DONE && rd_q) begin
      tx_d = {tx_q[RESP_W-2:0], 1'b0};
    end
  end

  always_comb begin
    if (long_q) begin
      f_cmd = sh_q[LONG_FRAME-1 -: CMD_W];
      f_dat = sh_q[CRC_W +: DATA_W];
    end else begin
      f_cmd = sh_q[SHORT_FRAME-1 -: CMD_W];
      f_dat = sh_q[DATA_W-1:0];
    end
    crc_ok  = (crc8_frame(f_cmd, f_dat) == sh_q[CRC_W-1:0]);
    wr_req  = eval_q && !f_cmd[0] && (!long_q || crc_ok);
    err_set = eval_q && !f_cmd[0] && long_q && !crc_ok;
  end

  assign wr_addr  = f_cmd[CMD_W-1:1];
  assign wr_data  = f_dat;
  assign rd_addr  = sh_q[CMD_W-1:1];
  assign miso_bit = rd_q & tx_q[RESP_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      rd_q   <= 1'b0;
      eval_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      rd_q   <= rd_d;
      eval_q <= eval_d;
      long_q <= long_d;
    end
  end
endmodule

// File: rtl/spi_regtgt.sv
module spi_regtgt
  import regtgt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 16'hA70C,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s, cs_act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_req, err_set, crc_chk_en, err_flag;
  logic              sclk_rise, sclk_fall, miso_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  regtgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .din({spi_mosi, spi_cs_n, spi_sclk}), .dout(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[2];
  assign cs_act = ~cs_n_s;

  regtgt_frame u_frame (
    .clk(clk), .rst_n(rst_sync_n), .sclk_s(sclk_s), .cs_act(cs_act),
    .mosi_s(mosi_s), .crc_chk_en(crc_chk_en), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_set(err_set), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .miso_bit(miso_bit)
  );

  regtgt_regfile #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .err_set(err_set), .rd_addr(rd_addr),
    .rd_data(rd_data), .crc_chk_en(crc_chk_en), .err_flag(err_flag)
  );

  assign spi_miso = ~spi_cs_n & miso_bit;
endmodule

// File: rtl/spi_regtgt_chk.sv
module spi_regtgt_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic cs_act,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic miso_bit,
  input logic wr_req,
  input logic err_flag
);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R4
  commit_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(sclk_rise));

  // R3
  miso_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !cs_act)
    (!sclk_fall && cs_act) |=> $stable(miso_bit));

  // R10
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso);
endmodule

bind spi_regtgt spi_regtgt_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .miso_bit(miso_bit), .wr_req(wr_req), .err_flag(err_flag)
);

// File: tb/spi_regtgt_tb_top.sv
`timescale 1ns/1ps
module spi_regtgt_tb_top;
  localparam int H = 8;
  localparam logic [15:0] ID = 16'hA70C;

  logic clk, rst_n, sclk, cs_n, mosi;
  logic miso;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;

  logic [15:0] mdl [0:15];
  logic        mdl_err;

  spi_regtgt dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bit-serial reference CRC, LSB first, poly 0x8C reflected, init 0
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  function automatic logic [7:0] frame_crc(input logic [7:0] cmd, input logic [15:0] d);
    return ref_crc(ref_crc(ref_crc(8'h00, cmd), d[15:8]), d[7:0]);
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    if (a == 0) return ID;
    if (a == 1) return {15'b0, mdl_err};
    if (a >= 3 && a <= 13) return mdl[a];
    return 16'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      rx = {rx[30:0], miso};
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic do_read(input int a, input string req);
    logic [31:0] rx;
    logic [7:0]  cmd;
    logic [15:0] e;
    cmd = {7'(a), 1'b1};
    xfer(32, {cmd, 24'h0}, rx);
    e = exp_read(a);
    check(rx[23:8] == e, req, {16'h0, rx[23:8]}, {16'h0, e});
    check(rx[7:0] == frame_crc(cmd, rx[23:8]), "R3", {24'h0, rx[7:0]},
          {24'h0, frame_crc(cmd, rx[23:8])});
    check(miso == 1'b0, "R10", {31'h0, miso}, 32'h0);
  endtask

  // writes according to the model's checking mode; bad=1 corrupts the CRC
  task automatic do_write(input int a, input logic [15:0] d, input bit bad);
    logic [31:0] rx;
    logic [7:0]  cmd;
    bit          chk_on;
    chk_on = mdl[3][0];
    cmd = {7'(a), 1'b0};
    if (chk_on) xfer(32, {cmd, d, frame_crc(cmd, d) ^ {7'h0, bad}}, rx);
    else xfer(24, {8'h0, cmd, d}, rx);
    if (chk_on && bad) mdl_err = 1'b1;
    else if (a >= 3 && a <= 13) mdl[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0;
    mdl_err = 1'b0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    check(miso == 1'b0, "R1", {31'h0, miso}, 32'h0);
    do_read(1, "R1");
    do_read(3, "R1");
    do_read(9, "R1");
    // R2 identity at address 0
    do_read(0, "R2");

    // R4 short write with checking off
    do_write(5, 16'h1234, 1'b0);
    do_read(5, "R4");
    do_write(13, 16'hBEEF, 1'b0);
    do_read(13, "R4");

    // R7 non-writable addresses
    do_write(0, 16'hFFFF, 1'b0);
    do_write(1, 16'hFFFF, 1'b0);
    do_write(2, 16'hFFFF, 1'b0);
    do_write(14, 16'hFFFF, 1'b0);
    do_write(40, 16'hFFFF, 1'b0);
    do_read(0, "R7");
    do_read(1, "R7");
    do_read(14, "R7");

    // R8 non-readable addresses
    do_read(2, "R8");
    do_read(40, "R8");
    do_read(127, "R8");

    // R9 abort mid-frame (20 of 24 bits)
    xfer(20, {12'h0, 8'h0C, 12'hABC}, rx);
    do_read(6, "R9");

    // R5 turn checking on, then a good long write
    do_write(3, 16'h0001, 1'b0);
    do_read(3, "R5");
    do_write(7, 16'hC3A5, 1'b0);
    do_read(7, "R5");
    // R5 a short frame is now incomplete
    xfer(24, {8'h0, 8'h10, 16'h5555}, rx);
    do_read(8, "R5");

    // R6 bad CRC discarded, sticky flag
    do_write(7, 16'h0F0F, 1'b1);
    do_read(7, "R6");
    do_read(1, "R6");
    do_write(9, 16'h2468, 1'b0);
    do_read(1, "R6");
    do_read(9, "R6");

    // R9 abort a long write after 28 bits
    xfer(28, {4'h0, 8'h14, 16'h7777}, rx);
    do_read(10, "R9");

    // random phase
    for (int n = 0; n < 80; n++) begin
      int a;
      logic [15:0] d;
      a = int'($urandom_range(0, 17));
      d = 16'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        do_read(a, "R2");
      end else begin
        if (a == 3) d[0] = ($urandom_range(0, 3) != 0);
        do_write(a, d, ($urandom_range(0, 4) == 0));
      end
    end
    for (int a = 0; a < 16; a++) do_read(a, "R7");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule